// File: doc/BRIEF.md
# Staged Operand Forwarding Pipeline

This block resolves source operands for an FPGA core whose functional units produce results over several cycles. A single multiplexer wide enough to pick from every in-flight result would not close timing there. Instead, forwarding is spread across a chain of register stages that runs alongside the functional-unit datapath and has the same depth.

An issued instruction enters the chain with its source register tags. It may also bring operand values that were already read from the register file, each marked as present. In every cycle, every stage sees the result buses of all functional units. An operand that is still missing takes a result whose destination tag equals its source tag. An operand that already holds a value keeps it. Each stage therefore needs only a small multiplexer: the operand's own value plus one input per result bus. The resolved operands, with a per-operand "present" flag, leave the last stage.

Hazard detection and stalling are handled elsewhere. The chain advances one stage every cycle.

Top module: `bypass_capture_pipe`

## Requirements
- R1: After reset, every stage is empty. `out_valid` and `out_have` stay 0 until an instruction issued after reset reaches the last stage.
- R2: An instruction presented with `iss_valid`=1 appears at the outputs with `out_valid`=1 exactly DEPTH (4) cycles later. Back-to-back issues emerge back to back and in order.
- R3: An operand issued with its `iss_have` bit set leaves with its issued value and `out_have`=1. Matching broadcasts do not change it.
- R4: A missing operand takes the data of a result bus with valid=1 and destination tag equal to its source tag. Broadcasts count if they appear in the issue cycle or in any of the following DEPTH-1 cycles. Such an operand leaves with that data and `out_have`=1.
- R5: After an operand has taken a value, later matching broadcasts are ignored, so the first matching result wins.
- R6: A broadcast with valid=0, or with a different destination tag, is not taken. An operand that never sees a match leaves with its issued value and `out_have`=0.
- R7: Source tag 0 never matches any broadcast, even a valid broadcast carrying destination tag 0.
- R8: When several buses carry the matching tag in the same cycle, the data of the highest-numbered bus (index NRES-1 highest) is taken.
- R9: A cycle with `iss_valid`=0 produces `out_valid`=0 DEPTH cycles later. Broadcasts do not mark the operands of an empty slot as present.
- R10: A broadcast that arrives DEPTH or more cycles after issue, when the operand has already left the chain, is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue slot holds an instruction |
| iss_tag | input | NSRC x TAGW (2x6) | Source register tag per operand |
| iss_data | input | NSRC x DW (2x32) | Operand value already read, if any |
| iss_have | input | NSRC (2) | Per operand: value in iss_data is already valid |
| res_valid | input | NRES (3) | Per bus: a result is broadcast this cycle |
| res_tag | input | NRES x TAGW (3x6) | Destination register tag per bus |
| res_data | input | NRES x DW (3x32) | Result data per bus |
| out_valid | output | 1 | Last stage holds an instruction |
| out_data | output | NSRC x DW (2x32) | Resolved operand values |
| out_have | output | NSRC (2) | Per operand: value was supplied at issue or taken from a bus |

## Verification
An instruction driven in cycle c is taken into the first stage at the next rising edge. It appears at the outputs after the DEPTH-th rising edge, so its operands are due in cycle c+DEPTH. The broadcasts that can reach it are those of cycles c through c+DEPTH-1. For every issue, the bench works out the expected operands from the per-cycle broadcast plan, using that window and the priority and tag-0 rules. It queues each expected result together with its due cycle. A falling-edge monitor counts rising edges since reset and compares the queue head in exactly its due cycle. In every other cycle it requires `out_valid`=0, so early, late or phantom outputs are all caught.

// File: rtl/bcp_pkg.sv
// Package: shared default sizes for the staged operand forwarding pipeline.
// Assumes: every module takes these as parameter defaults, so one edit resizes the block.
package bcp_pkg;
    localparam int BCP_NRES  = 3;   // result broadcast buses
    localparam int BCP_DEPTH = 4;   // stages, equal to datapath depth
    localparam int BCP_NSRC  = 2;   // source operands per instruction
    localparam int BCP_TAGW  = 6;   // register tag width
    localparam int BCP_DW    = 32;  // data width
endpackage

// File: rtl/bcp_pick.sv
// Module: bcp_pick
// Selects the broadcast, if any, that one travelling operand may take this cycle.
// Assumes: the highest-numbered matching bus has priority, and tag 0 matches nothing.
module bcp_pick #(
    parameter int NRES = bcp_pkg::BCP_NRES,
    parameter int TAGW = bcp_pkg::BCP_TAGW,
    parameter int DW   = bcp_pkg::BCP_DW
) (
    input  logic [TAGW-1:0]           want_tag,
    input  logic [NRES-1:0]           res_valid,
    input  logic [NRES-1:0][TAGW-1:0] res_tag,
    input  logic [NRES-1:0][DW-1:0]   res_data,
    output logic                      hit,
    output logic [DW-1:0]             hit_data
);
    // Scan buses upward so that a later (higher) match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int b = 0; b < NRES; b++) begin
            if (res_valid[b] && (res_tag[b] == want_tag) && (want_tag != '0)) begin
                hit      = 1'b1;
                hit_data = res_data[b];
            end
        end
    end
endmodule

// File: rtl/bcp_stage.sv
// Module: bcp_stage
// One register stage of the forwarding chain. Missing operands of a valid slot take a matching
// broadcast, and everything else passes through unchanged.
// Assumes: the chain never stalls; synchronous active-low reset empties the stage.
module bcp_stage #(
    parameter int NRES = bcp_pkg::BCP_NRES,
    parameter int NSRC = bcp_pkg::BCP_NSRC,
    parameter int TAGW = bcp_pkg::BCP_TAGW,
    parameter int DW   = bcp_pkg::BCP_DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NSRC-1:0][TAGW-1:0] in_tag,
    input  logic [NSRC-1:0][DW-1:0]   in_data,
    input  logic [NSRC-1:0]           in_have,
    input  logic [NRES-1:0]           res_valid,
    input  logic [NRES-1:0][TAGW-1:0] res_tag,
    input  logic [NRES-1:0][DW-1:0]   res_data,
    output logic                      q_valid,
    output logic [NSRC-1:0][TAGW-1:0] q_tag,
    output logic [NSRC-1:0][DW-1:0]   q_data,
    output logic [NSRC-1:0]           q_have
);
    logic [NSRC-1:0]         hit;
    logic [NSRC-1:0][DW-1:0] hit_data;
    logic [NSRC-1:0]         nxt_have;
    logic [NSRC-1:0][DW-1:0] nxt_data;

    for (genvar s = 0; s < NSRC; s++) begin : g_op
        bcp_pick #(.NRES(NRES), .TAGW(TAGW), .DW(DW)) u_pick (
            .want_tag (in_tag[s]),
            .res_valid(res_valid),
            .res_tag  (res_tag),
            .res_data (res_data),
            .hit      (hit[s]),
            .hit_data (hit_data[s])
        );

        // Take the broadcast only when the slot is live and the operand is still missing.
        always_comb begin
            if (in_valid && !in_have[s] && hit[s]) begin
                nxt_have[s] = 1'b1;
                nxt_data[s] = hit_data[s];
            end else begin
                nxt_have[s] = in_have[s];
                nxt_data[s] = in_data[s];
            end
        end

        // Independent view of which buses carry this operand's tag, for the checks below.
        logic [NRES-1:0] tag_eq;
        always_comb begin
            for (int b = 0; b < NRES; b++) begin
                tag_eq[b] = res_valid[b] && (res_tag[b] == in_tag[s]);
            end
        end

        assert_keep_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_have[s]) |=> (q_have[s] && q_data[s] == $past(in_data[s])));

        assert_tag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_have[s] && in_tag[s] == '0)
                |=> (!q_have[s] && q_data[s] == $past(in_data[s])));

        assert_no_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_have[s] && tag_eq == '0) |=> !q_have[s]);

        assert_top_bus_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_have[s] && in_tag[s] != '0 && tag_eq[NRES-1])
                |=> (q_have[s] && q_data[s] == $past(res_data[NRES-1])));

        assert_idle_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!q_valid && q_have[s] == $past(in_have[s])));
    end

    // Advance the slot by one stage, or empty it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_data  <= '0;
            q_have  <= '0;
        end else begin
            q_valid <= in_valid;
            q_tag   <= in_tag;
            q_data  <= nxt_data;
            q_have  <= in_valid ? nxt_have : in_have;
        end
    end
endmodule

// File: rtl/bypass_capture_pipe.sv
// Module: bypass_capture_pipe (top)
// Chain of DEPTH forwarding stages that runs beside the functional-unit datapath. Each stage
// watches all NRES result buses, so no stage needs more than an (NRES+1):1 select per operand.
// Assumes: no stalls; the issue inputs are sampled every cycle; results appear at the last stage.
module bypass_capture_pipe #(
    parameter int NRES  = bcp_pkg::BCP_NRES,
    parameter int DEPTH = bcp_pkg::BCP_DEPTH,
    parameter int NSRC  = bcp_pkg::BCP_NSRC,
    parameter int TAGW  = bcp_pkg::BCP_TAGW,
    parameter int DW    = bcp_pkg::BCP_DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic [NSRC-1:0][TAGW-1:0] iss_tag,
    input  logic [NSRC-1:0][DW-1:0]   iss_data,
    input  logic [NSRC-1:0]           iss_have,
    input  logic [NRES-1:0]           res_valid,
    input  logic [NRES-1:0][TAGW-1:0] res_tag,
    input  logic [NRES-1:0][DW-1:0]   res_data,
    output logic                      out_valid,
    output logic [NSRC-1:0][DW-1:0]   out_data,
    output logic [NSRC-1:0]           out_have
);
    localparam int NLINK = DEPTH + 1;

    // Link k feeds stage k; link 0 is the issue port, link DEPTH is the last stage's output.
    logic [NLINK-1:0]                     lk_valid;
    logic [NLINK-1:0][NSRC-1:0][TAGW-1:0] lk_tag;
    logic [NLINK-1:0][NSRC-1:0][DW-1:0]   lk_data;
    logic [NLINK-1:0][NSRC-1:0]           lk_have;

    assign lk_valid[0] = iss_valid;
    assign lk_tag[0]   = iss_tag;
    assign lk_data[0]  = iss_data;
    assign lk_have[0]  = iss_have;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        bcp_stage #(.NRES(NRES), .NSRC(NSRC), .TAGW(TAGW), .DW(DW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (lk_valid[k]),
            .in_tag   (lk_tag[k]),
            .in_data  (lk_data[k]),
            .in_have  (lk_have[k]),
            .res_valid(res_valid),
            .res_tag  (res_tag),
            .res_data (res_data),
            .q_valid  (lk_valid[k+1]),
            .q_tag    (lk_tag[k+1]),
            .q_data   (lk_data[k+1]),
            .q_have   (lk_have[k+1])
        );
    end

    assign out_valid = lk_valid[DEPTH];
    assign out_data  = lk_data[DEPTH];
    assign out_have  = lk_have[DEPTH];

    // An empty last stage never reports a present operand that came from a broadcast.
    assert_empty_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid[DEPTH-1] && lk_have[DEPTH-1] == '0) |=> (!out_valid && out_have == '0));
endmodule

// File: tb/tb_bypass_capture_pipe.sv
module tb_bypass_capture_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int NRES  = 3;
    localparam int DEPTH = 4;
    localparam int NSRC  = 2;
    localparam int TAGW  = 6;
    localparam int DW    = 32;
    localparam int NCYC  = 70;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      iss_valid;
    logic [NSRC-1:0][TAGW-1:0] iss_tag;
    logic [NSRC-1:0][DW-1:0]   iss_data;
    logic [NSRC-1:0]           iss_have;
    logic [NRES-1:0]           res_valid;
    logic [NRES-1:0][TAGW-1:0] res_tag;
    logic [NRES-1:0][DW-1:0]   res_data;
    logic                      out_valid;
    logic [NSRC-1:0][DW-1:0]   out_data;
    logic [NSRC-1:0]           out_have;

    always #(CLK_PERIOD/2) clk = ~clk;

    bypass_capture_pipe #(.NRES(NRES), .DEPTH(DEPTH), .NSRC(NSRC), .TAGW(TAGW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
        .iss_data(iss_data), .iss_have(iss_have), .res_valid(res_valid),
        .res_tag(res_tag), .res_data(res_data), .out_valid(out_valid),
        .out_data(out_data), .out_have(out_have)
    );

    // Per-cycle stimulus plan.
    logic            p_iv [NCYC];
    logic [TAGW-1:0] p_t  [NCYC][NSRC];
    logic [DW-1:0]   p_d  [NCYC][NSRC];
    logic            p_h  [NCYC][NSRC];
    string           p_req[NCYC];
    logic            p_rv [NCYC][NRES];
    logic [TAGW-1:0] p_rt [NCYC][NRES];
    logic [DW-1:0]   p_rd [NCYC][NRES];

    typedef struct {
        int                      due;
        logic [NSRC-1:0][DW-1:0] d;
        logic [NSRC-1:0]         h;
        string                   req;
    } exp_t;
    exp_t sb[$];

    int checks = 0;
    int fails  = 0;
    int pc     = 0;
    logic started = 1'b0;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, pc);
        end
    endtask

    task automatic set_issue(input int c, input logic [TAGW-1:0] t0, input logic [TAGW-1:0] t1,
                             input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                             input logic h0, input logic h1, input string req);
        p_iv[c] = 1'b1;
        p_t[c][0] = t0;  p_t[c][1] = t1;
        p_d[c][0] = d0;  p_d[c][1] = d1;
        p_h[c][0] = h0;  p_h[c][1] = h1;
        p_req[c] = req;
    endtask

    task automatic set_res(input int c, input int b, input logic v,
                           input logic [TAGW-1:0] t, input logic [DW-1:0] d);
        p_rv[c][b] = v;  p_rt[c][b] = t;  p_rd[c][b] = d;
    endtask

    // Driver side: expected operands from the rules (window c..c+DEPTH-1, top bus first, tag 0 never).
    task automatic push_expect(input int c);
        exp_t e;
        e.due = c + DEPTH;
        e.req = p_req[c];
        for (int s = 0; s < NSRC; s++) begin
            logic          have;
            logic [DW-1:0] val;
            have = p_h[c][s];
            val  = p_d[c][s];
            for (int j = c; j < c + DEPTH && j < NCYC; j++) begin
                if (!have && p_t[c][s] != '0) begin
                    for (int b = NRES - 1; b >= 0; b--) begin
                        if (!have && p_rv[j][b] && p_rt[j][b] == p_t[c][s]) begin
                            have = 1'b1;
                            val  = p_rd[j][b];
                        end
                    end
                end
            end
            e.d[s] = val;
            e.h[s] = have;
        end
        sb.push_back(e);
    endtask

    task automatic drive(input int i);
        if (i < NCYC) begin
            iss_valid = p_iv[i];
            for (int s = 0; s < NSRC; s++) begin
                iss_tag[s] = p_t[i][s]; iss_data[s] = p_d[i][s]; iss_have[s] = p_h[i][s];
            end
            for (int b = 0; b < NRES; b++) begin
                res_valid[b] = p_rv[i][b]; res_tag[b] = p_rt[i][b]; res_data[b] = p_rd[i][b];
            end
        end else begin
            iss_valid = 1'b0; iss_tag = '0; iss_data = '0; iss_have = '0;
            res_valid = '0; res_tag = '0; res_data = '0;
        end
    endtask

    // Count rising edges since the first post-reset issue slot.
    always @(posedge clk) if (started) pc <= pc + 1;

    // Monitor: compare the queue head exactly in its due cycle, else expect an empty output.
    always @(negedge clk) begin
        if (started && pc >= 1 && pc <= NCYC + DEPTH) begin
            if (sb.size() > 0 && sb[0].due == pc) begin
                exp_t e;
                e = sb.pop_front();
                check(out_valid == 1'b1, {e.req, " R2"}, "out_valid", 64'(out_valid), 64'd1);
                for (int s = 0; s < NSRC; s++) begin
                    check(out_have[s] == e.h[s], e.req, $sformatf("have[%0d]", s),
                          64'(out_have[s]), 64'(e.h[s]));
                    check(out_data[s] == e.d[s], e.req, $sformatf("data[%0d]", s),
                          64'(out_data[s]), 64'(e.d[s]));
                end
            end else begin
                check(out_valid == 1'b0, "R1 R9", "out_valid idle", 64'(out_valid), 64'd0);
            end
        end
    end

    initial begin
        for (int c = 0; c < NCYC; c++) begin
            p_iv[c] = 1'b0; p_req[c] = "";
            for (int s = 0; s < NSRC; s++) begin p_t[c][s] = '0; p_d[c][s] = '0; p_h[c][s] = 1'b0; end
            for (int b = 0; b < NRES; b++) begin p_rv[c][b] = 1'b0; p_rt[c][b] = '0; p_rd[c][b] = '0; end
        end
        // R3 held operand ignores bus; R6 invalid bus skipped; R4 capture one cycle after issue.
        set_issue(2, 6'd5, 6'd7, 32'h111, 32'h222, 1'b0, 1'b1, "R3 R4 R6");
        set_res(2, 2, 1'b0, 6'd5, 32'hDEAD);
        set_res(3, 0, 1'b1, 6'd5, 32'hA5A5);
        set_res(4, 1, 1'b1, 6'd7, 32'hBEEF);
        // R8 two buses match in the issue cycle; R5 a later match is ignored.
        set_issue(10, 6'd9, 6'd9, 32'h10, 32'h20, 1'b0, 1'b0, "R8 R5");
        set_res(10, 0, 1'b1, 6'd9, 32'h900);
        set_res(10, 2, 1'b1, 6'd9, 32'h902);
        set_res(10, 1, 1'b1, 6'd8, 32'h801);
        set_res(11, 1, 1'b1, 6'd9, 32'h911);
        // R7 tag zero never matches; R4 match in the last cycle of the window.
        set_issue(20, 6'd0, 6'd13, 32'h30, 32'h31, 1'b0, 1'b0, "R7 R4");
        set_res(20, 0, 1'b1, 6'd0, 32'hF0);
        set_res(23, 1, 1'b1, 6'd13, 32'h1313);
        // R10 matches arriving after the operands have left; R6 invalid bus earlier.
        set_issue(30, 6'd12, 6'd14, 32'h40, 32'h41, 1'b0, 1'b0, "R10 R6");
        set_res(31, 1, 1'b0, 6'd14, 32'h7777);
        set_res(34, 0, 1'b1, 6'd12, 32'h1212);
        set_res(35, 2, 1'b1, 6'd14, 32'h1414);
        // R2 back-to-back issues with a broadcast every cycle.
        for (int c = 40; c < 48; c++) begin
            set_issue(c, 6'((c % 8) + 1), 6'((c % 5) + 20), 32'(c * 16), 32'(c * 16 + 1),
                      1'(c % 2), 1'b0, "R2 R4 R10");
            set_res(c, c % 3, 1'b1, 6'(((c + 6) % 8) + 1), 32'(32'hC000 + c));
            set_res(c, (c + 1) % 3, 1'b1, 6'(((c + 1) % 5) + 20), 32'(32'hD000 + c));
        end
        for (int c = 48; c < 52; c++) begin
            set_res(c, c % 3, 1'b1, 6'(((c + 6) % 8) + 1), 32'(32'hC000 + c));
            set_res(c, (c + 1) % 3, 1'b1, 6'(((c + 1) % 5) + 20), 32'(32'hD000 + c));
        end
        // R9 empty slot with matching traffic.
        p_t[55][0] = 6'd3; p_t[55][1] = 6'd4;
        set_res(55, 0, 1'b1, 6'd3, 32'h3333);
        set_res(56, 1, 1'b1, 6'd4, 32'h4444);
        // R3 both operands present, matching buses everywhere.
        set_issue(60, 6'd2, 6'd2, 32'h60, 32'h61, 1'b1, 1'b1, "R3");
        set_res(60, 2, 1'b1, 6'd2, 32'h6262);
        set_res(62, 0, 1'b1, 6'd2, 32'h6363);
        for (int c = 0; c < NCYC; c++) if (p_iv[c]) push_expect(c);

        // R1: reset holds the chain empty even with live issue traffic.
        iss_valid = 1'b1; iss_tag = '0; iss_data = '1; iss_have = '1;
        res_valid = '0; res_tag = '0; res_data = '0;
        repeat (DEPTH + 2) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check(out_have == '0, "R1", "out_have in reset", 64'(out_have), 64'd0);

        rst_n = 1'b1;
        started = 1'b1;
        drive(0);
        for (int i = 1; i <= NCYC + DEPTH + 1; i++) begin
            @(negedge clk);
            drive(i);
        end
        @(negedge clk);
        check(sb.size() == 0, "R2", "results left unseen", 64'(sb.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule